// File: doc/BRIEF.md
# Multiplier-Accumulator with Guard-Bit Accumulator

This block is a single-cycle fixed-point multiply-accumulate unit. Each cycle it takes two operands, forms their product and then, as the opcode selects, loads the accumulator with it, adds it to the accumulator or subtracts it from the accumulator. A format selector for each operand says whether that operand is signed two's complement or unsigned. A squaring control feeds the first operand to both multiplier inputs. A rounding control adds half of a low-word unit to the new value, so the high word carries a biased-rounded result.

The accumulator is wider than a full product. The extra guard bits let long sums run past the 32-bit signed range without losing information. The accumulator leaves the block as three parts: a guard extension, a high word and a low word. An overflow flag shows when the value no longer fits a 32-bit signed word. Operand registers and instruction decoding sit outside the block.

Top module: `mac_guard`

## Requirements
- R1: While `rst_n` is low, the accumulator is zero and `ovf_o` is 0.
- R2: Opcode 2'b00 (load) writes the product into the accumulator at the next rising clock edge and discards the previous value.
- R3: Opcode 2'b01 (add) adds the product to the accumulator in one cycle.
- R4: Opcode 2'b10 (subtract) subtracts the product from the accumulator in one cycle.
- R5: When `a_sgn_i` is 1, `a_i` is read as two's complement, and when it is 0, as unsigned. `b_sgn_i` does the same for `b_i`. The two selectors act independently.
- R6: When `sq_i` is 1, the multiplier uses `a_i` with format `a_sgn_i` for both inputs, and `b_i` and `b_sgn_i` have no effect.
- R7: When `rnd_i` is 1 with opcode 2'b00, 2'b01 or 2'b10, 0x8000 is added to the new accumulator value. A low word of exactly 0x8000 always rounds up, with no correction toward even.
- R8: Opcode 2'b11 (hold) leaves the accumulator unchanged, and `rnd_i` has no effect with it.
- R9: `ovf_o` is 1 exactly when accumulator bits 39 down to 31 are not all equal. It follows the accumulator with no extra cycle.
- R10: The accumulator wraps modulo 2^40.
- R11: `acc_ext_o` is accumulator bits 39:32, `acc_hi_o` is bits 31:16 and `acc_lo_o` is bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | 00 load, 01 add, 10 subtract, 11 hold |
| rnd_i | input | 1 | Biased rounding of the new value |
| sq_i | input | 1 | Square `a_i` instead of multiplying by `b_i` |
| a_sgn_i | input | 1 | `a_i` is signed when 1 |
| b_sgn_i | input | 1 | `b_i` is signed when 1 |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| acc_ext_o | output | 8 | Guard extension, bits 39:32 |
| acc_hi_o | output | 16 | High word, bits 31:16 |
| acc_lo_o | output | 16 | Low word, bits 15:0 |
| ovf_o | output | 1 | Value outside the 32-bit signed range |

## Verification
The bench builds the block with its default 16-bit operands and 8 guard bits, and compares every step against a 64-bit reference accumulation that is folded back to 40 bits. With these widths, a run of 600 additions of the largest signed square passes the 32-bit boundary, where the overflow flag must rise. The same run carries on past the top of the guard bits, where the accumulator must wrap. The narrow operands also make the exact rounding tie (a low word of 0x8000) and the mixed signed/unsigned extremes simple vectors to hit.

// File: rtl/mac_guard.sv
module mac_guard #(
  parameter int W = 16,
  parameter int G = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_i,
  input  logic         rnd_i,
  input  logic         sq_i,
  input  logic         a_sgn_i,
  input  logic         b_sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [G-1:0] acc_ext_o,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o,
  output logic         ovf_o
);
  localparam int AW = 2*W + G;
  localparam int PW = 2*W + 2;
  localparam logic [1:0] OP_LOAD = 2'b00, OP_ADD = 2'b01, OP_SUB = 2'b10;
  localparam logic [AW-1:0] HALF = AW'(1) << (W-1);

  logic [AW-1:0] acc, nxt;
  logic [W-1:0] b_use;
  logic b_sgn_use;
  logic signed [W:0] xa, xb;
  logic signed [PW-1:0] prod;
  logic [AW-1:0] prod_x;
  logic [G:0] top;

  assign b_use     = sq_i ? a_i : b_i;
  assign b_sgn_use = sq_i ? a_sgn_i : b_sgn_i;
  assign xa = {a_sgn_i & a_i[W-1], a_i};
  assign xb = {b_sgn_use & b_use[W-1], b_use};
  assign prod = xa * xb;
  assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};

  always_comb begin
    case (op_i)
      OP_LOAD: nxt = prod_x;
      OP_ADD:  nxt = acc + prod_x;
      OP_SUB:  nxt = acc - prod_x;
      default: nxt = acc;
    endcase
    if (rnd_i && op_i != 2'b11) nxt = nxt + HALF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= nxt;

  assign acc_ext_o = acc[AW-1:2*W];
  assign acc_hi_o  = acc[2*W-1:W];
  assign acc_lo_o  = acc[W-1:0];
  assign top = acc[AW-1:2*W-1];
  assign ovf_o = !((&top) || !(|top));

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (acc == '0 && !ovf_o));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b11) |=> $stable(acc));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD && !rnd_i && a_sgn_i && b_sgn_use) |=> !ovf_o);
  // R5
  unsigned_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD && !rnd_i && !a_sgn_i && !b_sgn_use) |=> (acc_ext_o == '0));
  // R6
  square_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD && !rnd_i && sq_i) |=> !acc[AW-1]);
endmodule

// File: tb/mac_guard_tb.sv
`timescale 1ns/1ps
module mac_guard_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] op = 2'b11;
  logic rnd = 0, sq = 0, as = 0, bs = 0;
  logic [15:0] a = 0, b = 0;
  logic [7:0] ext;
  logic [15:0] hi, lo;
  logic ovf;
  int checks = 0, fails = 0;
  logic signed [63:0] m = 0;

  always #2.5 clk = ~clk;

  mac_guard u_dut (.clk(clk), .rst_n(rst_n), .op_i(op), .rnd_i(rnd), .sq_i(sq),
    .a_sgn_i(as), .b_sgn_i(bs), .a_i(a), .b_i(b),
    .acc_ext_o(ext), .acc_hi_o(hi), .acc_lo_o(lo), .ovf_o(ovf));

  // {op, rnd, sq, a_sgn, b_sgn, a, b}
  localparam logic [37:0] VEC [16] = '{
    {2'b00,1'b0,1'b0,1'b1,1'b1,16'h1234,16'hFEDC},
    {2'b01,1'b0,1'b0,1'b1,1'b0,16'h8001,16'hFFFF},
    {2'b10,1'b0,1'b0,1'b0,1'b1,16'hFFFF,16'h8000},
    {2'b01,1'b1,1'b0,1'b1,1'b1,16'h7FFF,16'h7FFF},
    {2'b10,1'b1,1'b0,1'b0,1'b0,16'hA5A5,16'h5A5A},
    {2'b01,1'b0,1'b1,1'b1,1'b0,16'h8000,16'h1111},
    {2'b01,1'b0,1'b1,1'b0,1'b1,16'hFFFF,16'h2222},
    {2'b11,1'b1,1'b0,1'b1,1'b1,16'h4444,16'h5555},
    {2'b10,1'b0,1'b1,1'b1,1'b1,16'hC000,16'h0000},
    {2'b00,1'b1,1'b0,1'b0,1'b0,16'h0003,16'h3000},
    {2'b01,1'b0,1'b0,1'b1,1'b1,16'h8000,16'h7FFF},
    {2'b10,1'b0,1'b0,1'b1,1'b1,16'h8000,16'h8000},
    {2'b01,1'b1,1'b0,1'b0,1'b1,16'h1357,16'hF00D},
    {2'b11,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF},
    {2'b10,1'b1,1'b1,1'b0,1'b0,16'hBEEF,16'h0000},
    {2'b01,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF}};

  function automatic logic signed [63:0] fold(input logic signed [63:0] v);
    return {{24{v[39]}}, v[39:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic r, input logic s,
                      input logic sa, input logic sb, input logic [15:0] va, input logic [15:0] vb);
    logic signed [63:0] ea, eb, p;
    logic [15:0] ub;
    logic usb;
    @(negedge clk);
    op = o; rnd = r; sq = s; as = sa; bs = sb; a = va; b = vb;
    ub = s ? va : vb;
    usb = s ? sa : sb;
    ea = sa ? {{48{va[15]}}, va} : {48'b0, va};
    eb = usb ? {{48{ub[15]}}, ub} : {48'b0, ub};
    p = ea * eb;
    case (o)
      2'b00: m = p;
      2'b01: m = m + p;
      2'b10: m = m - p;
      default: ;
    endcase
    if (r && o != 2'b11) m = m + 64'h8000;
    m = fold(m);
    @(posedge clk); #1;
  endtask

  task automatic cmp_model(input string tag);
    logic [8:0] t;
    t = m[39:31];
    check(tag, {ext, hi, lo}, m[39:0]);
    check({tag, "/R9"}, ovf, !((&t) || !(|t)));
  endtask

  initial begin
    #20000 $display("FAIL watchdog got=hung exp=done");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 reset value", {ext, hi, lo, ovf}, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 16; i++) begin
      logic [37:0] v;
      v = VEC[i];
      step(v[37:36], v[35], v[34], v[33], v[32], v[31:16], v[15:0]);
      case (v[37:36])
        2'b00: cmp_model("R2/R5 load");
        2'b01: cmp_model("R3/R5 add");
        2'b10: cmp_model("R4/R5 sub");
        default: cmp_model("R8 hold");
      endcase
    end

    step(2'b00, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    check("R11 split unsigned max", {ext, hi, lo}, {8'h00, 16'hFFFE, 16'h0001});
    check("R9 ovf unsigned max", ovf, 1);
    step(2'b00, 0, 0, 1, 0, 16'hFFFF, 16'hFFFF);
    check("R5 mixed format", {ext, hi, lo}, 40'hFF_FFFF_0001);
    step(2'b00, 0, 1, 1, 0, 16'hFFFF, 16'h1234);
    check("R6 square ignores b", {ext, hi, lo}, 40'h1);
    step(2'b00, 1, 0, 0, 0, 16'h0001, 16'h8000);
    check("R7 tie rounds up", {hi, lo}, {16'h0001, 16'h0000});
    step(2'b00, 1, 0, 0, 0, 16'h0001, 16'h7FFF);
    check("R7 below half", {hi, lo}, {16'h0000, 16'hFFFF});
    step(2'b11, 1, 0, 0, 0, 16'h1111, 16'h1111);
    check("R8 hold ignores round", {hi, lo}, {16'h0000, 16'hFFFF});
    step(2'b00, 0, 0, 1, 1, 16'h8000, 16'h8000);
    check("R2 load discards", {ext, hi, lo}, 40'h00_4000_0000);
    check("R9 in range", ovf, 0);
    step(2'b01, 0, 0, 1, 1, 16'h8000, 16'h8000);
    check("R9 past 32 bits", {ext, ovf}, {8'h00, 1'b1});
    for (int k = 0; k < 600; k++) begin
      step(2'b01, 0, 0, 1, 1, 16'h8000, 16'h8000);
      cmp_model("R10 wrap run");
    end
    step(2'b10, 0, 0, 0, 1, 16'hFFFF, 16'h8000);
    cmp_model("R4 sub mixed");

    @(negedge clk); rst_n = 0; #1;
    check("R1 async reset", {ext, hi, lo, ovf}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule